// File: doc/BRIEF.md
# Vertical Drive Line Counter with Sync Pull-In Window

This block counts horizontal lines and produces a vertical-drive pulse. In a windowed mode it locks to an incoming vertical sync strobe. A strobe counts only when the line count since the last frame event lies inside a window. The window's lower edge is fixed at line 48, and the mode picks its upper edge. If no strobe arrives before the window closes, the block makes its own frame event and restarts the count.

A separate mode ignores sync and free-runs. The free-run period comes from a 2-bit line-rate select. A stop mode suppresses the drive pulse entirely and holds the output high.

The sync strobe is taken from one of three sources: two composite-sync paths and one separate vertical-sync path. The output polarity is programmable. The mode and line-rate selects are sampled only at frame events, so a change never cuts a frame short.

Top module: `vsync_pullin`

## Requirements
- R1: During reset and in the first cycles after it, with invert at 0, `vd_out` is high.
- R2: The window's upper line bound for each mode is: 000 gives 849, 001 gives 725, 011 gives 637, 100 gives 613, 101 gives 363 and 110 gives 307. Both bounds of the window are inclusive.
- R3: A selected sync strobe is accepted when the line count since the last frame event is between 48 and the upper bound. Acceptance makes a frame event in the same clock edge: the count goes to 0 and a drive pulse starts.
- R4: A sync strobe that arrives while the count is below 48 is ignored, and the count keeps advancing on line strobes.
- R5: In a windowed mode with no accepted strobe, the line strobe arriving while the count equals the upper bound makes a frame event. The period is therefore bound + 1 lines.
- R6: Mode 010 ignores sync and makes a frame event every N line strobes. N is 562 for select 00, 525 for 01, 562 for 10 and 750 for 11.
- R7: Mode 111 produces no drive pulse and forces `vd_out` high whatever the invert input. Its count wraps every N lines, as in R6, and each wrap is a frame event that reloads the mode.
- R8: A drive pulse is active from its frame-event edge until the edge of the PULSE_LINES-th following line strobe. The default is 3.
- R9: With invert at 0 the drive is active-low. With invert at 1 it is active-high. `vd_out` is registered and follows the invert input one cycle later.
- R10: Source select 00 takes `vs_in[0]`, 01 takes `vs_in[1]`, and 10 or 11 takes `vs_in[2]`. Strobes on the other sources have no effect.
- R11: `mode_sel` and `fr_sel` are sampled only at a frame event. A frame event that loads mode 111 starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle strobe per horizontal line |
| vs_in | input | 3 | Vertical sync strobes, one per source |
| src_sel | input | 2 | Sync source select |
| mode_sel | input | 3 | Pull-in window / free-run / stop mode |
| fr_sel | input | 2 | Free-run line-rate select |
| vd_inv | input | 1 | Output polarity invert |
| vd_out | output | 1 | Vertical drive |

## Verification
The assertions assume that line and sync strobes are single-cycle pulses. They also assume the selects change only between strobes, so the count since a frame event never passes the largest window bound. The bench drives each strobe for exactly one cycle and spaces line strobes four cycles apart. It sends sync strobes in cycles with no line strobe, and it changes the mode, line-rate and invert inputs only while no pulse is being checked. The monitor ignores output edges caused by a polarity change. It accepts only pulses whose start line the driver predicted from the requirements.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

   localparam int unsigned WIN_LO  = 48;
   localparam int unsigned WIN_MAX = 849;

   typedef enum logic [2:0] {
      M_W849 = 3'b000,
      M_W725 = 3'b001,
      M_FREE = 3'b010,
      M_W637 = 3'b011,
      M_W613 = 3'b100,
      M_W363 = 3'b101,
      M_W307 = 3'b110,
      M_STOP = 3'b111
   } vmode_e;

   typedef struct packed {
      logic windowed;
      logic stop;
   } vclass_t;

   function automatic int unsigned win_hi(input vmode_e m);
      case (m)
         M_W849:  return 849;
         M_W725:  return 725;
         M_W637:  return 637;
         M_W613:  return 613;
         M_W363:  return 363;
         M_W307:  return 307;
         default: return 0;
      endcase
   endfunction

   function automatic int unsigned run_len(input logic [1:0] s);
      case (s)
         2'b01:   return 525;
         2'b11:   return 750;
         default: return 562;
      endcase
   endfunction

endpackage

// File: rtl/vsp_mode_dec.sv
module vsp_mode_dec #(
   parameter int CNT_W = 10
) (
   input  vsp_pkg::vmode_e   mode,
   input  logic [1:0]        fr,
   output vsp_pkg::vclass_t  cls,
   output logic [CNT_W-1:0]  hi,
   output logic [CNT_W-1:0]  len_m1
);
   import vsp_pkg::*;

   always_comb begin
      cls.stop     = (mode == M_STOP);
      cls.windowed = (mode != M_STOP) && (mode != M_FREE);
      hi           = CNT_W'(win_hi(mode));
      len_m1       = CNT_W'(run_len(fr) - 1);
   end

endmodule

// File: rtl/vsp_src_mux.sv
module vsp_src_mux #(
   parameter int NUM_SRC = 3
) (
   input  logic [NUM_SRC-1:0] vs_in,
   input  logic [1:0]         sel,
   output logic               sync
);
   localparam logic [1:0] LAST = 2'(NUM_SRC - 1);

   if (NUM_SRC < 2 || NUM_SRC > 4) begin : g_bad_src
      $error("vsp_src_mux: NUM_SRC must be 2..4");
   end

   logic [1:0]         idx;
   logic [NUM_SRC-1:0] hit;

   assign idx = (sel > LAST) ? LAST : sel;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
      assign hit[g] = vs_in[g] && (idx == 2'(g));
   end

   assign sync = |hit;

endmodule

// File: rtl/vsp_pulse_gen.sv
module vsp_pulse_gen #(
   parameter int PULSE_LINES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cancel,
   input  logic line_stb,
   output logic active_nxt,
   output logic active
);
   localparam int PW = $clog2(PULSE_LINES + 1);

   if (PULSE_LINES < 1) begin : g_bad_len
      $error("vsp_pulse_gen: PULSE_LINES must be at least 1");
   end

   if (PULSE_LINES == 1) begin : g_flag
      logic on_q;
      always_comb begin
         if (start)                 active_nxt = 1'b1;
         else if (cancel)           active_nxt = 1'b0;
         else if (line_stb)         active_nxt = 1'b0;
         else                       active_nxt = on_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) on_q <= 1'b0;
         else        on_q <= active_nxt;
      end
      assign active = on_q;
   end else begin : g_count
      logic [PW-1:0] left_q, left_d;
      always_comb begin
         if (start)                          left_d = PW'(PULSE_LINES);
         else if (cancel)                    left_d = '0;
         else if (line_stb && left_q != '0)  left_d = left_q - 1'b1;
         else                                left_d = left_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) left_q <= '0;
         else        left_q <= left_d;
      end
      assign active_nxt = (left_d != '0);
      assign active     = (left_q != '0);
   end

endmodule

// File: rtl/vsync_pullin.sv
module vsync_pullin #(
   parameter int CNT_W       = 10,
   parameter int NUM_SRC     = 3,
   parameter int PULSE_LINES = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_stb,
   input  logic [NUM_SRC-1:0] vs_in,
   input  logic [1:0]         src_sel,
   input  logic [2:0]         mode_sel,
   input  logic [1:0]         fr_sel,
   input  logic               vd_inv,
   output logic               vd_out
);
   import vsp_pkg::*;

   if ((1 << CNT_W) <= WIN_MAX) begin : g_bad_w
      $error("vsync_pullin: CNT_W too narrow for the widest window");
   end

   localparam logic [CNT_W-1:0] LO = CNT_W'(WIN_LO);

   vmode_e           act_mode, mode_nxt;
   logic [1:0]       act_fr;
   logic [CNT_W-1:0] cnt;
   vclass_t          cls;
   logic [CNT_W-1:0] hi, len_m1;
   logic             sync_sel, take_sync, expire, wrap, frame_evt;
   logic             stop_nxt, act_stop, pulse_nxt, pulse_on, vd_q;

   vsp_mode_dec #(.CNT_W(CNT_W)) u_dec (
      .mode   (act_mode),
      .fr     (act_fr),
      .cls    (cls),
      .hi     (hi),
      .len_m1 (len_m1)
   );

   vsp_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
      .vs_in (vs_in),
      .sel   (src_sel),
      .sync  (sync_sel)
   );

   assign take_sync = sync_sel && cls.windowed && (cnt >= LO) && (cnt <= hi);
   assign expire    = line_stb && cls.windowed && (cnt == hi);
   assign wrap      = line_stb && !cls.windowed && (cnt == len_m1);
   assign frame_evt = take_sync || expire || wrap;
   assign act_stop  = cls.stop;
   assign mode_nxt  = frame_evt ? vmode_e'(mode_sel) : act_mode;
   assign stop_nxt  = (mode_nxt == M_STOP);

   vsp_pulse_gen #(.PULSE_LINES(PULSE_LINES)) u_pulse (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (frame_evt && !stop_nxt),
      .cancel     (frame_evt && stop_nxt),
      .line_stb   (line_stb),
      .active_nxt (pulse_nxt),
      .active     (pulse_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_mode <= M_W849;
         act_fr   <= 2'b00;
         cnt      <= '0;
         vd_q     <= 1'b1;
      end else begin
         act_mode <= mode_nxt;
         if (frame_evt) act_fr <= fr_sel;
         if (frame_evt)     cnt <= '0;
         else if (line_stb) cnt <= cnt + 1'b1;
         vd_q <= stop_nxt ? 1'b1 : (pulse_nxt ^ ~vd_inv);
      end
   end

   assign vd_out = vd_q;

endmodule

// File: rtl/vsp_checker.sv
module vsp_checker #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_stb,
   input logic             vd_out,
   input logic [CNT_W-1:0] cnt,
   input logic             frame_evt,
   input logic             act_stop,
   input logic             sync_sel,
   input logic             pulse_on
);

   p_stop_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      act_stop |-> vd_out)
      else $error("stop mode output not high");

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(849))
      else $error("line count beyond widest window");

   p_evt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt |=> (cnt == '0))
      else $error("count not restarted after frame event");

   p_early_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_sel && cnt < CNT_W'(48)) |=> (cnt == $past(cnt) + CNT_W'($past(line_stb))))
      else $error("early sync disturbed the count");

   p_pulse_from_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_on) |-> $past(frame_evt))
      else $error("drive pulse began without a frame event");

endmodule

bind vsync_pullin vsp_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_stb  (line_stb),
   .vd_out    (vd_out),
   .cnt       (cnt),
   .frame_evt (frame_evt),
   .act_stop  (act_stop),
   .sync_sel  (sync_sel),
   .pulse_on  (pulse_on)
);

// File: tb/tb_vsync_pullin.sv
module tb_vsync_pullin;

   typedef struct {
      int    line;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_stb = 1'b0;
   logic [2:0] vs_in = '0;
   logic [1:0] src_sel = 2'b00;
   logic [2:0] mode_sel = 3'b000;
   logic [1:0] fr_sel = 2'b00;
   logic       vd_inv = 1'b0;
   logic       vd_out;

   int   n_chk = 0;
   int   n_fail = 0;
   int   gl = 0;
   int   mon_lines = 0;
   bit   mon_en = 1'b0;
   bit   prev_act = 1'b0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   vsync_pullin dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_stb (line_stb),
      .vs_in    (vs_in),
      .src_sel  (src_sel),
      .mode_sel (mode_sel),
      .fr_sel   (fr_sel),
      .vd_inv   (vd_inv),
      .vd_out   (vd_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input int line, input string tag);
      exp_t e;
      e.line = line;
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) line_stb = 1'b1;
         @(negedge clk) line_stb = 1'b0;
         gl++;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic sync(input int idx, input bit accept, input string tag);
      @(negedge clk) vs_in[idx] = 1'b1;
      if (accept) push(gl, tag);
      @(negedge clk) vs_in = '0;
      @(negedge clk);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk)
      if (rst_n && line_stb) mon_lines++;

   // scoreboard monitor: every drive-pulse start must match a predicted line
   always @(negedge clk) begin : mon
      bit a;
      exp_t e;
      a = vd_inv ? vd_out : !vd_out;
      if (mon_en && a && !prev_act) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 unexpected pulse: actual line %0d expected none", mon_lines);
         end else begin
            e = exp_q.pop_front();
            check(e.tag, mon_lines, e.line);
         end
      end
      prev_act = a;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 output during reset", vd_out, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 output after reset", vd_out, 1);
      mon_en = 1'b1;

      // first frame runs in mode 000; mode 101 is pending (R11)
      mode_sel = 3'b101;
      fr_sel   = 2'b01;
      lines(48);
      sync(0, 1'b1, "R3 accept at lower bound 48");
      lines(2);
      check("R8 pulse still active after 2 lines", vd_out, 0);
      lines(1);
      check("R8 pulse ends on 3rd line", vd_out, 1);

      // R4: early strobes ignored (n=10, n=47)
      lines(7);
      sync(0, 1'b0, "");
      check("R4 early sync ignored", vd_out, 1);
      lines(37);
      sync(0, 1'b0, "");
      lines(316);
      sync(0, 1'b1, "R2 accept at upper bound 363");

      // R10: source selection
      src_sel = 2'b01;
      lines(100);
      sync(0, 1'b0, "");
      sync(2, 1'b0, "");
      sync(1, 1'b1, "R10 source 01 takes vs_in[1]");
      src_sel = 2'b11;
      lines(60);
      sync(1, 1'b0, "");
      sync(2, 1'b1, "R10 source 11 takes vs_in[2]");
      src_sel = 2'b10;

      // R5 / R11: expiry at 364 lines while free-run mode is pending
      mode_sel = 3'b010;
      lines(363);
      push(gl + 1, "R5 R11 window expiry at 364 lines");
      lines(1);

      // R6: free-run at 525, sync ignored
      lines(100);
      sync(2, 1'b0, "");
      lines(424);
      push(gl + 1, "R6 free-run period 525");
      lines(1);

      // R7: stop mode loaded at next wrap, no pulse
      mode_sel = 3'b111;
      lines(525);
      check("R7 no pulse when stop loaded", vd_out, 1);
      mon_en = 1'b0;
      vd_inv = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 stop high with invert", vd_out, 1);
      vd_inv = 1'b0;
      repeat (3) @(negedge clk);
      mon_en = 1'b1;
      mode_sel = 3'b110;
      lines(524);
      check("R7 stop holds high through frame", vd_out, 1);
      push(gl + 1, "R7 stop wrap at 525 reloads mode");
      lines(1);
      lines(3);

      // R9: inverted polarity
      mon_en = 1'b0;
      vd_inv = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 inverted idle level", vd_out, 0);
      mon_en = 1'b1;
      lines(100);
      sync(2, 1'b1, "R9 inverted pulse start");
      check("R9 inverted active level", vd_out, 1);
      lines(3);
      check("R9 inverted pulse end", vd_out, 0);

      // R5 with bound 307, then R6 at 750
      mode_sel = 3'b010;
      fr_sel   = 2'b11;
      lines(304);
      push(gl + 1, "R5 window expiry at 308 lines");
      lines(1);
      lines(749);
      push(gl + 1, "R6 free-run period 750");
      lines(1);
      lines(5);
      check("R3 all predicted pulses seen", exp_q.size(), 0);
      finish_run();
   end

endmodule